// File: doc/BRIEF.md
# Debug Register Access Scan Chain

This block is a serial access path that lets an external debugger read and write a bank of debug registers over the test port. The debugger shifts a 38-bit packet through the chain: one direction flag, a 5-bit register index and a 32-bit data word. When the packet is committed, the block either stores the data word into the indexed register or fetches that register's value into the data part of the chain. A fetched value comes out during the next data scan. The capture phase of a scan leaves the chain as it is, so read data is always one scan behind the request.

The chain responds only while two conditions both hold: the scan-select has picked this chain, and the port is in its internal-test mode. The test-port state machine sits outside the block and supplies one-cycle strobes for capture, shift and update. The bank holds 32 words of 32 bits, written so that it maps onto a single-port block RAM with synchronous read.

Top module: `dbgscan_chain`

## Requirements
- R1: After a synchronous reset every bit of the 38-bit chain is 0, so `tdo` reads 0 and the first scan returns an all-zero packet.
- R2: Each shift strobe while the chain is active moves the chain one place toward bit 0. `tdi` enters bit 37 and `tdo` always presents bit 0, so a packet goes in and comes out least significant bit first.
- R3: An update strobe while active, with bit 37 equal to 1 (write), stores bits 31:0 into the register indexed by bits 36:32 and leaves the chain contents unchanged.
- R4: An update strobe while active, with bit 37 equal to 0 (read), replaces bits 31:0 of the chain with the indexed register's value one clock later and keeps bits 37:32. The next scan shifts that value out.
- R5: A capture strobe has no effect on the chain or on the registers.
- R6: When the chain is not selected or the port is not in internal-test mode, shift and update strobes change neither the chain nor any register.
- R7: Shifting never modifies the register bank, even when the chain holds a write packet. Only an update commits a write.
- R8: All 32 register indices select distinct storage, and each one can be written and read back independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| chain_sel | input | 1 | Scan-select has picked this chain |
| mode_intest | input | 1 | Test port is in internal-test mode |
| capture_dr | input | 1 | One-cycle capture strobe |
| shift_dr | input | 1 | One-cycle-per-bit shift strobe |
| update_dr | input | 1 | One-cycle update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0) |

## Verification
The assertions assume the test-port controller drives at most one of the three strobes in any cycle, and never shifts in the clock cycle directly after an update, because that cycle is reserved for the register read to land in the chain. The bench drives each strobe in its own cycle. After every update it inserts an idle cycle, which the port's state sequence also guarantees. It writes all 32 registers, reads each one back with a capture strobe placed before the read-out scan, and repeats gated and uncommitted scans so that their absence of effect shows in later scan output.

// File: rtl/dbgscan_pkg.sv
package dbgscan_pkg;
  localparam int DEF_ADDR_W = 5;
  localparam int DEF_DATA_W = 32;

  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_dir_e;
endpackage

// File: rtl/dbgscan_ctrl.sv
module dbgscan_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic chain_sel,
  input  logic mode_intest,
  input  logic capture_dr,
  input  logic shift_dr,
  input  logic update_dr,
  input  logic dir_bit,
  output logic sh_en,
  output logic wr_en,
  output logic rd_en,
  output logic rd_land
);
  import dbgscan_pkg::*;

  logic active;
  logic upd_en;

  assign active = chain_sel & mode_intest;
  assign sh_en  = active & shift_dr;
  assign upd_en = active & update_dr;
  assign wr_en  = upd_en & (dir_bit == ACC_WRITE);
  assign rd_en  = upd_en & (dir_bit == ACC_READ);

  always_ff @(posedge clk) begin
    if (rst) rd_land <= 1'b0;
    else     rd_land <= rd_en;
  end

  // Input protocol: one strobe per cycle.
  p_one_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({capture_dr, shift_dr, update_dr}));

  // Input protocol: no shift in the cycle where read data lands (R4).
  p_no_shift_on_land_r4: assert property (@(posedge clk) disable iff (rst)
    rd_land |-> !shift_dr);

  // Inactive chain never commits an access.
  p_gated_r6: assert property (@(posedge clk) disable iff (rst)
    !(chain_sel && mode_intest) |-> !(wr_en || rd_en || sh_en));
endmodule

// File: rtl/dbgscan_regbank.sv
module dbgscan_regbank #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

  p_wr_rd_excl_r3: assert property (@(posedge clk) !(we && re));
endmodule

// File: rtl/dbgscan_shreg.sv
module dbgscan_shreg #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sh_en,
  input  logic                     ld_en,
  input  logic                     tdi,
  input  logic [DATA_W-1:0]        ld_data,
  output logic [ADDR_W+DATA_W:0]   chain
);
  localparam int CHAIN_W = ADDR_W + DATA_W + 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else if (sh_en) begin
      chain <= {tdi, chain[CHAIN_W-1:1]};
    end else if (ld_en) begin
      chain[DATA_W-1:0] <= ld_data;
    end
  end

  p_shift_r2: assert property (@(posedge clk) disable iff (rst)
    sh_en |=> (chain[CHAIN_W-2:0] == $past(chain[CHAIN_W-1:1])) &&
              (chain[CHAIN_W-1] == $past(tdi)));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!sh_en && !ld_en) |=> $stable(chain));

  p_load_keeps_hdr_r4: assert property (@(posedge clk) disable iff (rst)
    (ld_en && !sh_en) |=> $stable(chain[CHAIN_W-1:DATA_W]));
endmodule

// File: rtl/dbgscan_chain.sv
module dbgscan_chain #(
  parameter int ADDR_W = dbgscan_pkg::DEF_ADDR_W,
  parameter int DATA_W = dbgscan_pkg::DEF_DATA_W
) (
  input  logic clk,
  input  logic rst,
  input  logic chain_sel,
  input  logic mode_intest,
  input  logic capture_dr,
  input  logic shift_dr,
  input  logic update_dr,
  input  logic tdi,
  output logic tdo
);
  localparam int CHAIN_W = ADDR_W + DATA_W + 1;
  localparam int DIR_BIT = CHAIN_W - 1;

  logic [CHAIN_W-1:0] chain;
  logic [DATA_W-1:0]  rdata;
  logic               sh_en, wr_en, rd_en, rd_land;

  dbgscan_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .chain_sel  (chain_sel),
    .mode_intest(mode_intest),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .dir_bit    (chain[DIR_BIT]),
    .sh_en      (sh_en),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .rd_land    (rd_land)
  );

  dbgscan_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk  (clk),
    .we   (wr_en),
    .re   (rd_en),
    .addr (chain[DIR_BIT-1:DATA_W]),
    .wdata(chain[DATA_W-1:0]),
    .rdata(rdata)
  );

  dbgscan_shreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sr (
    .clk    (clk),
    .rst    (rst),
    .sh_en  (sh_en),
    .ld_en  (rd_land),
    .tdi    (tdi),
    .ld_data(rdata),
    .chain  (chain)
  );

  assign tdo = chain[0];

  p_write_keeps_chain_r3: assert property (@(posedge clk) disable iff (rst)
    (chain_sel && mode_intest && update_dr && chain[DIR_BIT]) |=> $stable(chain));

  p_inactive_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!(chain_sel && mode_intest) && !rd_land) |=> $stable(chain));
endmodule

// File: tb/dbgscan_chain_tb.sv
module dbgscan_chain_tb;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam int CW = AW + DW + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chain_sel = 1'b0, mode_intest = 1'b0;
  logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic tdo;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dbgscan_chain #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .chain_sel(chain_sel), .mode_intest(mode_intest),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .tdo(tdo)
  );

  function automatic logic [DW-1:0] f(int a);
    return (a + 1) * 32'h9E37_79B9;
  endfunction

  function automatic logic [CW-1:0] pk(logic w, int a, logic [DW-1:0] d);
    return {w, a[AW-1:0], d};
  endfunction

  task automatic chk(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic scan(input logic [CW-1:0] din, output logic [CW-1:0] dout);
    for (int i = 0; i < CW; i++) begin
      @(negedge clk);
      dout[i] = tdo;
      tdi = din[i];
      shift_dr = 1'b1;
    end
    @(negedge clk);
    shift_dr = 1'b0;
  endtask

  task automatic upd();
    @(negedge clk); update_dr = 1'b1;
    @(negedge clk); update_dr = 1'b0;
    @(negedge clk);
  endtask

  task automatic cap();
    @(negedge clk); capture_dr = 1'b1;
    @(negedge clk); capture_dr = 1'b0;
  endtask

  initial begin
    logic [CW-1:0] o, x;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 tdo after reset", {{(CW-1){1'b0}}, tdo}, '0);
    chain_sel = 1'b1; mode_intest = 1'b1;

    // R1 / R2: reset contents come out, then the packet shifted in
    x = {1'b0, 5'h15, 32'hC0FF_EE11};
    scan(x, o);
    chk("R1 first scan zero", o, '0);
    scan(pk(1'b0, 9, 32'h0), o);
    chk("R2 lsb-first round trip", o, x);

    // R3 / R8: write every register
    for (int a = 0; a < 32; a++) begin
      scan(pk(1'b1, a, f(a)), o);
      upd();
    end
    // R3: write left the chain unchanged
    scan(pk(1'b0, 0, 32'hFFFF_FFFF), o);
    chk("R3 chain kept after write", o, pk(1'b1, 31, f(31)));
    upd();
    cap();

    // R4 / R5 / R8: read back each register, capture before each scan
    for (int a = 1; a <= 32; a++) begin
      scan(pk(1'b0, a % 32, 32'h5A5A_5A5A), o);
      chk("R4 R8 read back", o, pk(1'b0, a - 1, f(a - 1)));
      if (a < 32) begin
        upd();
        cap();
        cap();
      end
    end

    // R6: gated scans and updates have no effect
    x = pk(1'b0, 5, 32'h0BAD_F00D);
    scan(x, o);
    chain_sel = 1'b0;
    scan(pk(1'b1, 3, 32'hDEAD_0003), o);
    upd();
    chain_sel = 1'b1; mode_intest = 1'b0;
    scan(pk(1'b1, 4, 32'hDEAD_0004), o);
    upd();
    mode_intest = 1'b1;
    scan(pk(1'b0, 3, 32'h0), o);
    chk("R6 chain untouched while gated", o, x);
    upd();
    scan(pk(1'b0, 4, 32'h0), o);
    chk("R6 reg 3 untouched", o, pk(1'b0, 3, f(3)));
    upd();

    // R7: a write packet that is shifted but never committed
    scan(pk(1'b1, 7, 32'h1234_5678), o);
    chk("R6 reg 4 untouched", o, pk(1'b0, 4, f(4)));
    scan(pk(1'b0, 7, 32'h0), o);
    chk("R2 uncommitted packet out", o, pk(1'b1, 7, 32'h1234_5678));
    upd();
    scan(pk(1'b0, 0, 32'h0), o);
    chk("R7 reg 7 unchanged by shift", o, pk(1'b0, 7, f(7)));

    // R3 / R8: overwrite one register and confirm its neighbour
    scan(pk(1'b1, 30, 32'hA5A5_0030), o);
    upd();
    scan(pk(1'b0, 30, 32'h0), o);
    upd();
    scan(pk(1'b0, 29, 32'h0), o);
    chk("R3 overwrite", o, pk(1'b0, 30, 32'hA5A5_0030));
    upd();
    scan(pk(1'b0, 0, 32'h0), o);
    chk("R8 neighbour intact", o, pk(1'b0, 29, f(29)));
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(negedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule